// File: doc/BRIEF.md
# Event Performance Counter Unit

This block sits beside a processor core and counts what the core does. It holds one free-running cycle counter and two general counters. Each general counter picks one line of a vector of single-cycle event pulses through an 8-bit select code. A single control word turns all three counters on or off together. The same word also holds the per-counter interrupt enables, sticky overflow flags, the select codes, a slow-rate option for the cycle counter and two self-clearing zeroing strobes.

Software reaches the unit through a small register port with four addresses. Address 0 is the control word, 1 is the cycle count, 2 is general counter A and 3 is general counter B. The three counters cannot be switched on or off one by one. To park a general counter, software points it at a select code with no live input, for example 0x20. Overflow flags clear by writing one to them. Writing back any value just read therefore leaves every other setting as it was. One level interrupt is raised while any flag is set whose enable is also set.

Top module: `perf_event_monitor`

## Requirements
- R1: After reset every count register and the control word read 0 and `irq_o` is low.
- R2: While control bit 0 (run) is 0, no counter changes except through a register write or a zeroing strobe.
- R3: Control bits 27:20 select the event of counter A and bits 19:12 the event of counter B. A select code c below 32 makes the counter add one on every clock with run set and `evt_i[c]` high.
- R4: A select code of 32 or above, including the parking code 0x20, never advances its counter.
- R5: With run set and control bit 3 clear, the cycle counter adds one every clock. With bit 3 set it adds one every 64th clock, the first step falling 64 clocks after a write that also sets bit 2.
- R6: Writing 1 to control bit 1 zeroes both general counters, and writing 1 to bit 2 zeroes the cycle counter and its divider phase. Both bits read back 0 and act only in the cycle of the write.
- R7: Addresses 1, 2 and 3 read and write the cycle counter, counter A and counter B. A write takes effect in place of an increment falling in the same cycle.
- R8: When a counter steps from 0xFFFFFFFF to 0, its flag is set: bit 8 for counter A, bit 9 for counter B and bit 10 for the cycle counter.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it. A wrap in the same cycle as a clear leaves the flag set.
- R10: `irq_o` is high exactly while some flag is set together with its enable: bit 4 for counter A, bit 5 for counter B and bit 6 for the cycle counter.
- R11: The control word reads back run, bit 3, the enables, the flags and both select codes, and reads 0 in every other bit. Writing back a value just read changes no field other than clearing the flags that were set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 cycle, 2 counter A, 3 counter B) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| evt_i | input | 32 | Single-cycle event pulses, one line per select code 0..31 |
| irq_o | output | 1 | Shared overflow interrupt, level |

## Verification
Two pairs of actions can land in the same cycle, and each is set up on purpose. In the first, a counter is preloaded to 0xFFFFFFFF and its event pulse is held high. A control write that clears the matching flag then falls on the wrapping edge, and the flag must still read set with the count at 0. In the second, a count write meets a live event in the same cycle. The written value must appear unchanged, and it must step by one only on the following edge.

// File: rtl/pem_pkg.sv
package pem_pkg;

    localparam int CNT_W  = 32;
    localparam int SEL_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CYC  = 2'd1;
    localparam logic [ADDR_W-1:0] A_EVA  = 2'd2;
    localparam logic [ADDR_W-1:0] A_EVB  = 2'd3;

    // control word bit positions (software decodes these)
    localparam int B_RUN    = 0;
    localparam int B_CLR_EV = 1;
    localparam int B_CLR_CY = 2;
    localparam int B_DIV    = 3;
    localparam int B_IE_LO  = 4;   // 4 A, 5 B, 6 cycle
    localparam int B_OV_LO  = 8;   // 8 A, 9 B, 10 cycle
    localparam int B_SELB   = 12;  // 19:12
    localparam int B_SELA   = 20;  // 27:20

    // index of each counter inside the 3-bit enable / flag vectors
    localparam int IX_A   = 0;
    localparam int IX_B   = 1;
    localparam int IX_CYC = 2;

    typedef struct packed {
        logic             run;
        logic             div;
        logic [2:0]       ie;
        logic [2:0]       ovf;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
    } ctrl_t;

endpackage

// File: rtl/pem_event_sel.sv
module pem_event_sel #(
    parameter int N_EVT = 32,
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [N_EVT-1:0] evt_i,
    output logic             hit_o
);

    // codes with no line behind them leave hit_o low
    always_comb begin
        hit_o = 1'b0;
        for (int k = 0; k < N_EVT; k++) begin
            if (sel_i == SEL_W'(k)) hit_o = evt_i[k];
        end
    end

endmodule

// File: rtl/pem_prescale.sv
module pem_prescale #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic div_i,
    input  logic clear_i,
    output logic tick_o
);

    localparam logic [DIV_LOG2-1:0] PH_MAX = '1;

    logic [DIV_LOG2-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (clear_i)    ph_d = '0;
        else if (run_i) ph_d = ph_q + 1'b1;
        tick_o = run_i && !clear_i && (!div_i || ph_q == PH_MAX);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end

    AST_PRE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (ph_q == '0)); // R6

endmodule

// File: rtl/pem_counter.sv
module pem_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (clear_i) begin
            cnt_d = '0;
        end else if (load_i) begin
            cnt_d = load_val_i;
        end else if (inc_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = &cnt_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !load_i && !clear_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
    AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !clear_i) |=> (cnt_q == $past(load_val_i))); // R7

endmodule

// File: rtl/perf_event_monitor.sv
module perf_event_monitor
    import pem_pkg::*;
#(
    parameter int N_EVT    = 32,
    parameter int DIV_LOG2 = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    input  logic [N_EVT-1:0]  evt_i,
    output logic              irq_o
);

    localparam int N_GEN = 2;

    ctrl_t ctrl_d, ctrl_q;

    logic                       ctrl_wr, clr_ev, clr_cy;
    logic                       cyc_load, cyc_tick, cyc_wrap;
    logic [CNT_W-1:0]           cyc_cnt;
    logic [N_GEN-1:0]           gen_load, gen_hit, gen_wrap;
    logic [N_GEN-1:0][SEL_W-1:0] gen_sel;
    logic [N_GEN-1:0][CNT_W-1:0] gen_cnt;

    assign gen_sel[IX_A] = ctrl_q.sel_a;
    assign gen_sel[IX_B] = ctrl_q.sel_b;

    always_comb begin
        ctrl_wr  = reg_wr_i && (reg_addr_i == A_CTRL);
        clr_ev   = ctrl_wr && reg_wdata_i[B_CLR_EV];
        clr_cy   = ctrl_wr && reg_wdata_i[B_CLR_CY];
        cyc_load = reg_wr_i && (reg_addr_i == A_CYC);
        gen_load[IX_A] = reg_wr_i && (reg_addr_i == A_EVA);
        gen_load[IX_B] = reg_wr_i && (reg_addr_i == A_EVB);

        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.run   = reg_wdata_i[B_RUN];
            ctrl_d.div   = reg_wdata_i[B_DIV];
            ctrl_d.ie    = reg_wdata_i[B_IE_LO +: 3];
            ctrl_d.sel_a = reg_wdata_i[B_SELA +: SEL_W];
            ctrl_d.sel_b = reg_wdata_i[B_SELB +: SEL_W];
            ctrl_d.ovf   = ctrl_q.ovf & ~reg_wdata_i[B_OV_LO +: 3];
        end
        // a wrap in the same cycle outranks the clear
        ctrl_d.ovf[IX_A]   = ctrl_d.ovf[IX_A]   | gen_wrap[IX_A];
        ctrl_d.ovf[IX_B]   = ctrl_d.ovf[IX_B]   | gen_wrap[IX_B];
        ctrl_d.ovf[IX_CYC] = ctrl_d.ovf[IX_CYC] | cyc_wrap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    pem_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (ctrl_q.run),
        .div_i   (ctrl_q.div),
        .clear_i (clr_cy),
        .tick_o  (cyc_tick)
    );

    pem_counter #(.CNT_W(CNT_W)) u_cyc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (clr_cy),
        .load_i     (cyc_load),
        .load_val_i (reg_wdata_i),
        .inc_i      (cyc_tick),
        .count_o    (cyc_cnt),
        .wrap_o     (cyc_wrap)
    );

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        pem_event_sel #(.N_EVT(N_EVT), .SEL_W(SEL_W)) u_sel (
            .sel_i (gen_sel[g]),
            .evt_i (evt_i),
            .hit_o (gen_hit[g])
        );
        pem_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .clear_i    (clr_ev),
            .load_i     (gen_load[g]),
            .load_val_i (reg_wdata_i),
            .inc_i      (ctrl_q.run && gen_hit[g]),
            .count_o    (gen_cnt[g]),
            .wrap_o     (gen_wrap[g])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_CTRL: begin
                reg_rdata_o[B_RUN]             = ctrl_q.run;
                reg_rdata_o[B_DIV]             = ctrl_q.div;
                reg_rdata_o[B_IE_LO +: 3]      = ctrl_q.ie;
                reg_rdata_o[B_OV_LO +: 3]      = ctrl_q.ovf;
                reg_rdata_o[B_SELA +: SEL_W]   = ctrl_q.sel_a;
                reg_rdata_o[B_SELB +: SEL_W]   = ctrl_q.sel_b;
            end
            A_CYC:   reg_rdata_o = cyc_cnt;
            A_EVA:   reg_rdata_o = gen_cnt[IX_A];
            default: reg_rdata_o = gen_cnt[IX_B];
        endcase
    end

    assign irq_o = |(ctrl_q.ovf & ctrl_q.ie);

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_wrap |=> ctrl_q.ovf[IX_CYC]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_q.ovf[IX_A] && !(ctrl_wr && reg_wdata_i[B_OV_LO + IX_A])) |=> ctrl_q.ovf[IX_A]); // R9
    AST_EVT_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_ev |=> (gen_cnt[IX_A] == '0 && gen_cnt[IX_B] == '0)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_q.run && !reg_wr_i) |=> ($stable(cyc_cnt) && $stable(gen_cnt))); // R2
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ctrl_q.ovf != 3'b000)); // R10

endmodule

// File: tb/perf_event_monitor_tb.sv
module perf_event_monitor_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_event_monitor dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_i       (evt),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic [7:0]  sel_a;
        logic [7:0]  sel_b;
        logic [31:0] pat;
        logic [7:0]  n;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{8'd0,   8'd1,    32'h0000_0001, 8'd5, 32'd5, 32'd0},
        '{8'd3,   8'd3,    32'h0000_0008, 8'd7, 32'd7, 32'd7},
        '{8'd31,  8'h20,   32'hFFFF_FFFF, 8'd4, 32'd4, 32'd0},
        '{8'hFF,  8'd17,   32'h0002_0000, 8'd3, 32'd0, 32'd3}
    };

    function automatic logic [31:0] mk(input logic run, input logic div, input logic [2:0] ie,
                                       input logic [7:0] sa, input logic [7:0] sb,
                                       input logic clr_ev, input logic clr_cy, input logic [2:0] ovc);
        logic [31:0] w;
        w = '0;
        w[0] = run; w[1] = clr_ev; w[2] = clr_cy; w[3] = div;
        w[6:4] = ie; w[10:8] = ovc; w[27:20] = sa; w[19:12] = sb;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    logic [31:0] v, v2;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 irq at reset", {31'h0, irq}, 32'h0);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < 4; i++) begin
            wr(2'd0, mk(1'b1, 1'b0, 3'b000, VECS[i].sel_a, VECS[i].sel_b, 1'b1, 1'b1, 3'b000));
            evt = VECS[i].pat;
            repeat (int'(VECS[i].n)) @(negedge clk);
            evt = '0;
            wr(2'd0, mk(1'b0, 1'b0, 3'b000, VECS[i].sel_a, VECS[i].sel_b, 1'b0, 1'b0, 3'b000));
            rd(2'd2, v); chk("R3/R4 counter A", v, VECS[i].exp_a);
            rd(2'd3, v); chk("R3/R4 counter B", v, VECS[i].exp_b);
            rd(2'd1, v); chk("R5 cycle count", v, 32'(VECS[i].n) + 32'd1);
        end

        // R2: run clear, events ignored
        evt = '1;
        repeat (5) @(negedge clk);
        evt = '0;
        rd(2'd3, v); chk("R2 counter B held", v, 32'd3);
        rd(2'd1, v); chk("R2 cycle held", v, 32'd4);

        // R6: bit1 zeroes general counters only; strobes read 0 (R11)
        wr(2'd0, mk(1'b0, 1'b0, 3'b000, 8'd0, 8'd0, 1'b1, 1'b0, 3'b000));
        rd(2'd3, v); chk("R6 counter B zeroed", v, 32'd0);
        rd(2'd1, v); chk("R6 cycle untouched", v, 32'd4);
        rd(2'd0, v); chk("R6 strobe bits read 0", v & 32'h6, 32'h0);

        // R7 register access and write priority
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, v); chk("R7 cycle write", v, 32'h1234_5678);
        evt[0] = 1'b1;
        wr(2'd0, mk(1'b1, 1'b0, 3'b000, 8'd0, 8'h20, 1'b0, 1'b0, 3'b000));
        wr(2'd2, 32'h55);
        rd(2'd2, v); chk("R7 write beats increment", v, 32'h55);
        @(negedge clk);
        rd(2'd2, v); chk("R7 step after write", v, 32'h56);
        evt = '0;

        // R8 / R10: counter B wraps
        wr(2'd0, mk(1'b0, 1'b0, 3'b010, 8'h20, 8'd0, 1'b0, 1'b0, 3'b000));
        wr(2'd3, 32'hFFFF_FFFE);
        wr(2'd0, mk(1'b1, 1'b0, 3'b010, 8'h20, 8'd0, 1'b0, 1'b0, 3'b000));
        evt[0] = 1'b1; @(negedge clk); evt = '0;
        rd(2'd0, v); chk("R8 no flag before wrap", (v >> 8) & 32'h7, 32'h0);
        evt[0] = 1'b1; @(negedge clk); evt = '0;
        rd(2'd3, v); chk("R8 counter B wrapped", v, 32'h0);
        rd(2'd0, v); chk("R8 flag B set", (v >> 8) & 32'h7, 32'h2);
        chk("R10 irq with flag and enable", {31'h0, irq}, 32'h1);

        // R9 write 0 leaves flag, write 1 clears
        wr(2'd0, mk(1'b1, 1'b0, 3'b010, 8'h20, 8'd0, 1'b0, 1'b0, 3'b000));
        rd(2'd0, v); chk("R9 zero write keeps flag", (v >> 8) & 32'h7, 32'h2);
        wr(2'd0, mk(1'b1, 1'b0, 3'b010, 8'h20, 8'd0, 1'b0, 1'b0, 3'b010));
        rd(2'd0, v); chk("R9 one write clears flag", (v >> 8) & 32'h7, 32'h0);
        chk("R10 irq drops", {31'h0, irq}, 32'h0);

        // R9 set beats clear in the same cycle
        wr(2'd3, 32'hFFFF_FFFF);
        evt[0] = 1'b1;
        wr(2'd0, mk(1'b1, 1'b0, 3'b010, 8'h20, 8'd0, 1'b0, 1'b0, 3'b010));
        evt = '0;
        rd(2'd3, v); chk("R9 collide count", v, 32'h0);
        rd(2'd0, v); chk("R9 set wins over clear", (v >> 8) & 32'h7, 32'h2);

        // R10 enable cleared masks irq, flag stays
        wr(2'd0, mk(1'b0, 1'b0, 3'b000, 8'h20, 8'd0, 1'b0, 1'b0, 3'b000));
        chk("R10 masked irq", {31'h0, irq}, 32'h0);
        rd(2'd0, v); chk("R10 flag kept while masked", (v >> 8) & 32'h7, 32'h2);

        // R8 / R10 cycle counter wrap
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, mk(1'b1, 1'b0, 3'b100, 8'h20, 8'h20, 1'b0, 1'b0, 3'b010));
        @(negedge clk);
        rd(2'd0, v); chk("R8 cycle flag", (v >> 8) & 32'h7, 32'h4);
        chk("R10 cycle irq", {31'h0, irq}, 32'h1);

        // R5 divided rate
        wr(2'd0, mk(1'b1, 1'b1, 3'b000, 8'h20, 8'h20, 1'b0, 1'b1, 3'b100));
        repeat (63) @(negedge clk);
        rd(2'd1, v); chk("R5 divided before step", v, 32'h0);
        @(negedge clk);
        rd(2'd1, v); chk("R5 divided first step", v, 32'h1);

        // R11 readback mask and write-back
        wr(2'd0, 32'hFFFF_FFF8 & ~32'h1);
        rd(2'd0, v); chk("R11 readable bits", v, 32'h0FFF_F078);
        wr(2'd0, v);
        rd(2'd0, v2); chk("R11 write-back keeps fields", v2, v);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule